// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block drives the address of a synchronous burst memory through a four-beat burst. A burst opens when either of two start strobes is high on a rising clock edge. One strobe comes from the processor side and the other from the cache-controller side. On that edge the block registers the external address. After the burst opens, each edge on which the advance input is high moves the two low address bits to the next position in the burst. The upper address bits do not change during a burst.

The ordering input is registered together with the start address. A low value gives linear ordering: the low bits count up modulo four from the start. A high value gives interleaved ordering: the low bits are the start bits XOR a beat count that runs 0, 1, 2, 3. The block holds the registered ordering until the next start.

A two-state controller tracks the burst. `ST_IDLE` is the state after reset, before any burst has started. `ST_BURST` means a start address is registered. The transition `go_start` moves `ST_IDLE` to `ST_BURST` on any strobe. The transition `go_restart` stays in `ST_BURST` and reloads on any strobe. The transition `go_step` stays in `ST_BURST` and advances one beat. The transition `go_hold` keeps the current state and values when neither a strobe nor a qualifying advance is present. The outputs are the current address, the beat position, a burst-live flag, and a flag that names which strobe opened the burst.

Top module: `burst_seq_gen`

## Requirements
- R1: After reset, `addr_out` is 0, `beat_pos` is 0, `burst_live` is 0 and `owner_cpu` is 0.
- R2: A rising edge with `strb_cpu` or `strb_ctl` high registers `addr_in`. From the next cycle, `addr_out` equals `addr_in`, `beat_pos` is 0 and `burst_live` is 1.
- R3: When both strobes are high on the same edge, the processor strobe wins and `owner_cpu` becomes 1. A start by `strb_ctl` alone sets `owner_cpu` to 0, and a start by `strb_cpu` alone sets it to 1.
- R4: During a burst, an edge with `adv` high and no strobe increments `beat_pos` modulo 4. An edge with `adv` low and no strobe leaves `addr_out` and `beat_pos` unchanged.
- R5: With `mode_ilv` = 0 registered at the start, `addr_out[1:0]` = (start low bits + `beat_pos`) mod 4. The upper bits always equal the upper bits of the start address.
- R6: With `mode_ilv` = 1 registered at the start, `addr_out[1:0]` = start low bits XOR `beat_pos`.
- R7: After four advances, `addr_out` returns to the start address, and later advances repeat the same sequence.
- R8: A strobe on the same edge as `adv` high performs a load: `beat_pos` becomes 0 and `addr_out` becomes the new `addr_in`.
- R9: Changing `mode_ilv` during a burst does not change the ordering until the next strobe.
- R10: While no burst has started, `adv` is ignored: `addr_out` stays 0 and `burst_live` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| strb_cpu | input | 1 | Processor-side burst start strobe |
| strb_ctl | input | 1 | Cache-controller-side burst start strobe |
| adv | input | 1 | Advance to the next beat |
| mode_ilv | input | 1 | Ordering select: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst address |
| beat_pos | output | BURST_BITS | Beat count within the burst |
| burst_live | output | 1 | High once a burst has been started |
| owner_cpu | output | 1 | 1 if the processor strobe started the burst |

## Verification
Assertions check on every cycle:
- the beat is cleared by a load;
- the beat steps by one on an advance;
- the state is held when there is no strobe and no advance;
- the processor strobe wins when both strobes are high;
- the ordering and upper bits stay fixed through a burst;
- the controller stays idle when `adv` arrives before any start.

The actual address values are shown only by the bench's scenarios. These are the linear and interleaved sequences from several start offsets, the wrap back to the start, and a load that overrides a simultaneous advance.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bsg_state_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } bsg_order_e;
endpackage

// File: rtl/bsg_strobe_arb.sv
module bsg_strobe_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_cpu,
    input  logic strb_ctl,
    output logic load,
    output logic load_cpu
);
    always_comb begin
        load     = strb_cpu | strb_ctl;
        load_cpu = strb_cpu;
    end

    // R3
    cpu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_cpu && strb_ctl) |-> (load && load_cpu));
endmodule

// File: rtl/bsg_ctrl.sv
module bsg_ctrl
    import bsg_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  load_cpu,
    input  logic                  adv,
    input  logic                  mode_ilv,
    input  logic [ADDR_W-1:0]     addr_in,
    output bsg_state_e            state,
    output logic [ADDR_W-1:0]     base,
    output logic [BURST_BITS-1:0] beat,
    output bsg_order_e            order,
    output logic                  owner
);
    bsg_state_e            state_nx;
    logic [ADDR_W-1:0]     base_nx;
    logic [BURST_BITS-1:0] beat_nx;
    bsg_order_e            order_nx;
    logic                  owner_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            base  <= '0;
            beat  <= '0;
            order <= ORD_LINEAR;
            owner <= 1'b0;
        end else begin
            state <= state_nx;
            base  <= base_nx;
            beat  <= beat_nx;
            order <= order_nx;
            owner <= owner_nx;
        end
    end

    always_comb begin
        state_nx = state;
        base_nx  = base;
        beat_nx  = beat;
        order_nx = order;
        owner_nx = owner;
        unique case (state)
            ST_IDLE: begin
                if (load) begin
                    state_nx = ST_BURST;
                    base_nx  = addr_in;
                    beat_nx  = '0;
                    order_nx = bsg_order_e'(mode_ilv);
                    owner_nx = load_cpu;
                end
            end
            ST_BURST: begin
                if (load) begin
                    base_nx  = addr_in;
                    beat_nx  = '0;
                    order_nx = bsg_order_e'(mode_ilv);
                    owner_nx = load_cpu;
                end else if (adv) begin
                    beat_nx = beat + 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // R2
    load_clears_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (beat == '0 && state == ST_BURST));
    // R4
    step_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BURST && adv && !load) |=> beat == BURST_BITS'($past(beat) + 1'b1));
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> ($stable(beat) && $stable(base)));
    // R9
    order_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(order));
    // R10
    idle_ignores_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !load) |=> (state == ST_IDLE && beat == '0));
endmodule

// File: rtl/bsg_addr_map.sv
module bsg_addr_map
    import bsg_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BURST_BITS = 2
) (
    input  logic [ADDR_W-1:0]     base,
    input  logic [BURST_BITS-1:0] beat,
    input  bsg_order_e            order,
    output logic [ADDR_W-1:0]     addr
);
    localparam int UPPER_W = ADDR_W - BURST_BITS;

    logic [BURST_BITS-1:0] lo;

    always_comb begin
        unique case (order)
            ORD_LINEAR:     lo = base[BURST_BITS-1:0] + beat;
            ORD_INTERLEAVE: lo = base[BURST_BITS-1:0] ^ beat;
            default:        lo = base[BURST_BITS-1:0];
        endcase
    end

    generate
        if (UPPER_W > 0) begin : g_upper
            assign addr = {base[ADDR_W-1:BURST_BITS], lo};
        end else begin : g_flat
            assign addr = lo[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
    import bsg_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strb_cpu,
    input  logic                  strb_ctl,
    input  logic                  adv,
    input  logic                  mode_ilv,
    input  logic [ADDR_W-1:0]     addr_in,
    output logic [ADDR_W-1:0]     addr_out,
    output logic [BURST_BITS-1:0] beat_pos,
    output logic                  burst_live,
    output logic                  owner_cpu
);
    logic                  load;
    logic                  load_cpu;
    bsg_state_e            state;
    logic [ADDR_W-1:0]     base;
    logic [BURST_BITS-1:0] beat;
    bsg_order_e            order;
    logic                  owner;

    bsg_strobe_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb_cpu (strb_cpu),
        .strb_ctl (strb_ctl),
        .load     (load),
        .load_cpu (load_cpu)
    );

    bsg_ctrl #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_cpu (load_cpu),
        .adv      (adv),
        .mode_ilv (mode_ilv),
        .addr_in  (addr_in),
        .state    (state),
        .base     (base),
        .beat     (beat),
        .order    (order),
        .owner    (owner)
    );

    bsg_addr_map #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_map (
        .base  (base),
        .beat  (beat),
        .order (order),
        .addr  (addr_out)
    );

    always_comb begin
        beat_pos   = beat;
        burst_live = (state == ST_BURST);
        owner_cpu  = owner;
    end

    // R5
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> addr_out[ADDR_W-1:BURST_BITS] == $past(addr_out[ADDR_W-1:BURST_BITS]));
    // R3
    owner_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb_cpu |=> owner_cpu);
    // R2
    load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_cpu || strb_ctl) |=> addr_out == $past(addr_in));
endmodule

// File: tb/burst_seq_gen_tb_top.sv
module burst_seq_gen_tb_top;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strb_cpu = 1'b0, strb_ctl = 1'b0, adv = 1'b0, mode_ilv = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;
    logic [1:0]    beat_pos;
    logic          burst_live, owner_cpu;
    int            total = 0, bad = 0;
    bit            finished = 0;

    always #2.5 clk = ~clk;

    burst_seq_gen #(.ADDR_W(AW), .BURST_BITS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .strb_cpu(strb_cpu), .strb_ctl(strb_ctl),
        .adv(adv), .mode_ilv(mode_ilv), .addr_in(addr_in), .addr_out(addr_out),
        .beat_pos(beat_pos), .burst_live(burst_live), .owner_cpu(owner_cpu)
    );

    task automatic step(input logic c, input logic k, input logic a,
                        input logic m, input logic [AW-1:0] ad);
        @(negedge clk);
        strb_cpu = c; strb_ctl = k; adv = a; mode_ilv = m; addr_in = ad;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [AW-1:0] ea,
                       input logic [1:0] eb, input logic el);
        total++;
        if (addr_out !== ea || beat_pos !== eb || burst_live !== el) begin
            bad++;
            $display("FAIL %s: addr=%h beat=%0d live=%0b expected addr=%h beat=%0d live=%0b",
                     req, addr_out, beat_pos, burst_live, ea, eb, el);
        end
    endtask

    task automatic chk_owner(input string req, input logic eo);
        total++;
        if (owner_cpu !== eo) begin
            bad++;
            $display("FAIL %s: owner_cpu=%0b expected %0b", req, owner_cpu, eo);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] s,
                                               input int b, input bit ilv);
        logic [1:0] lo;
        lo = ilv ? (s[1:0] ^ 2'(b)) : 2'((int'(s[1:0]) + b) % 4);
        return {s[AW-1:2], lo};
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        step(0, 0, 0, 0, 16'hFFFF);
        step(0, 0, 0, 0, 16'hFFFF);
        chk("R1 reset", '0, 2'd0, 1'b0);
        chk_owner("R1 reset owner", 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_idle_adv();
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 1, 0, 16'h7777);
            chk("R10 idle advance ignored", '0, 2'd0, 1'b0);
        end
    endtask

    task automatic t_sequence(input logic [AW-1:0] s, input bit ilv, input bit cpu);
        step(cpu, !cpu, 0, ilv, s);
        chk("R2 load", s, 2'd0, 1'b1);
        chk_owner("R3 single strobe owner", cpu);
        for (int b = 1; b <= 6; b++) begin
            step(0, 0, 1, ilv, 16'h0);
            if (b % 4 == 0)
                chk("R7 wrap to start", s, 2'(b % 4), 1'b1);
            else
                chk(ilv ? "R6 interleaved step" : "R5 linear step",
                    exp_addr(s, b % 4, ilv), 2'(b % 4), 1'b1);
        end
        step(0, 0, 0, ilv, 16'h0);
        chk("R4 hold without advance", exp_addr(s, 2, ilv), 2'd2, 1'b1);
    endtask

    task automatic t_priority();
        step(1, 1, 0, 0, 16'h4440);
        chk("R3 both strobes load", 16'h4440, 2'd0, 1'b1);
        chk_owner("R3 processor wins", 1'b1);
        step(0, 1, 0, 0, 16'h4444);
        chk_owner("R3 controller start", 1'b0);
        step(1, 0, 0, 0, 16'h4448);
        chk_owner("R3 processor start", 1'b1);
    endtask

    task automatic t_load_over_adv();
        step(0, 1, 0, 0, 16'h2220);
        step(0, 0, 1, 0, 16'h0);
        step(0, 0, 1, 0, 16'h0);
        chk("R8 setup beat 2", 16'h2222, 2'd2, 1'b1);
        step(1, 0, 1, 1, 16'h5553);
        chk("R8 load beats advance", 16'h5553, 2'd0, 1'b1);
        step(0, 0, 1, 0, 16'h0);
        chk("R8 new burst uses new mode", 16'h5552, 2'd1, 1'b1);
    endtask

    task automatic t_mode_hold();
        step(0, 1, 0, 0, 16'h1231);
        step(0, 0, 1, 1, 16'h0);
        chk("R9 mode change ignored step1", 16'h1232, 2'd1, 1'b1);
        step(0, 0, 1, 1, 16'h0);
        chk("R9 mode change ignored step2", 16'h1233, 2'd2, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle_adv();
        t_sequence(16'hABC2, 1'b0, 1'b0);
        t_sequence(16'hABC1, 1'b1, 1'b1);
        t_sequence(16'h0F03, 1'b1, 1'b0);
        t_priority();
        t_load_over_adv();
        t_mode_hold();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule